// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block arbitrates one synchronous step of a shared register file that several processor ports access at once. In a step each port may present one write (valid, address, data). Writes that target distinct locations all commit together. Writes that land on the same location are settled by a rule picked at run time through a two-bit mode input. The choices are exclusive (any collision is a violation), arbitrary (one writer wins), lowest-index priority, and common-value (legal only when all writers agree).

Each port also owns a combinational read port. A read issued during a step returns the contents as they were before that step, because writes only take effect at the closing clock edge. After each step every port receives a one-cycle grant pulse showing whether its write was committed. Ports whose write was rejected as an illegal collision receive an error pulse instead. The arbitrary rule uses a rotating pointer, so its choice is repeatable and can be predicted.

Top module: `cw_resolver`

## Requirements
- R1: After reset every location reads 0, and grant_o and err_o are all 0.
- R2: In a step, valid writes to pairwise distinct addresses all commit at the closing clock edge. Each such port sees grant_o high for the following cycle.
- R3: A read presented during a step cycle returns the value from before that step's writes. The new value is visible from the next cycle.
- R4: Priority mode (mode_i = 2): among writers to one location, the lowest port index commits and alone is granted. The others get neither grant nor error.
- R5: Arbitrary mode (mode_i = 1): a pointer starts at 0 after reset and advances by one, modulo the port count, on every step cycle. It holds on cycles with step_i low. Among writers to one location, the first index at or after the pointer (cyclically) commits and alone is granted.
- R6: Common mode (mode_i = 3): when all writers to one location present equal data, all of them are granted and the location takes that value.
- R7: Common mode: when writers to one location present differing data, each of them gets err_o high and no grant, and the location keeps its old value. Writes to other locations in the same step still commit.
- R8: Exclusive mode (mode_i = 0): any two or more writers to one location all get err_o high and no grant, and the location is not updated. Non-colliding writes commit.
- R9: grant_o and err_o are single-cycle pulses that follow a step. They are 0 in any cycle whose previous cycle had step_i low.
- R10: With step_i low, wr_valid_i, wr_data_i and mode_i have no effect: no location changes and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Marks the current cycle as a step |
| mode_i | input | 2 | Conflict rule: 0 exclusive, 1 arbitrary, 2 priority, 3 common |
| wr_valid_i | input | NPORTS | Per-port write request |
| wr_addr_i | input | NPORTS*AW | Per-port write address, port p at bits p*AW |
| wr_data_i | input | NPORTS*DW | Per-port write data, port p at bits p*DW |
| rd_addr_i | input | NPORTS*AW | Per-port read address |
| rd_data_o | output | NPORTS*DW | Per-port read data (pre-step contents) |
| grant_o | output | NPORTS | Per-port pulse: write committed in last step |
| err_o | output | NPORTS | Per-port pulse: write rejected as illegal collision |

## Verification
The hardest case to reach is a predicted winner in arbitrary mode. The pointer that decides it depends on how many step cycles have passed since reset, and nothing at the ports shows it. The bench keeps its own count of issued steps and derives the expected winner from that count alone. It drives full four-way collisions and partial ones at several pointer positions. It also inserts idle cycles with live requests between them, to show that the pointer holds when no step is marked.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    MODE_EXCL   = 2'd0,
    MODE_ARB    = 2'd1,
    MODE_PRIO   = 2'd2,
    MODE_COMMON = 2'd3
  } mode_e;
endpackage

// File: rtl/cw_match.sv
// Pairwise comparison of all write requests: same location, same data.
module cw_match #(
  parameter int NPORTS = 4,
  parameter int AW     = 3,
  parameter int DW     = 8
) (
  input  logic [NPORTS-1:0]             valid_i,
  input  logic [NPORTS*AW-1:0]          addr_i,
  input  logic [NPORTS*DW-1:0]          data_i,
  output logic [NPORTS-1:0][NPORTS-1:0] hit_o,
  output logic [NPORTS-1:0][NPORTS-1:0] same_o
);
  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_row
    for (genvar gj = 0; gj < NPORTS; gj++) begin : g_col
      assign hit_o[gi][gj]  = valid_i[gi] & valid_i[gj] &
                              (addr_i[gi*AW +: AW] == addr_i[gj*AW +: AW]);
      assign same_o[gi][gj] = (data_i[gi*DW +: DW] == data_i[gj*DW +: DW]);
    end
  end
endmodule

// File: rtl/cw_arbiter.sv
// Applies the selected conflict rule to every port.
module cw_arbiter #(
  parameter int NPORTS = 4,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS-1:0]             valid_i,
  input  logic [NPORTS-1:0][NPORTS-1:0] hit_i,
  input  logic [NPORTS-1:0][NPORTS-1:0] same_i,
  input  cw_pkg::mode_e                 mode_i,
  input  logic [PW-1:0]                 ptr_i,
  output logic [NPORTS-1:0]             grant_o,
  output logic [NPORTS-1:0]             err_o
);
  import cw_pkg::*;

  function automatic int rot_dist(input int k, input int p);
    return (k - p + NPORTS) % NPORTS;
  endfunction

  always_comb begin
    grant_o = '0;
    err_o   = '0;
    for (int i = 0; i < NPORTS; i++) begin
      logic collide;
      logic prio_lose;
      logic rot_lose;
      logic data_ok;
      collide   = 1'b0;
      prio_lose = 1'b0;
      rot_lose  = 1'b0;
      data_ok   = 1'b1;
      for (int j = 0; j < NPORTS; j++) begin
        if (j != i && hit_i[i][j]) begin
          collide = 1'b1;
          if (j < i) prio_lose = 1'b1;
          if (rot_dist(j, int'(ptr_i)) < rot_dist(i, int'(ptr_i))) rot_lose = 1'b1;
          if (!same_i[i][j]) data_ok = 1'b0;
        end
      end
      if (valid_i[i]) begin
        unique case (mode_i)
          MODE_EXCL: begin
            grant_o[i] = ~collide;
            err_o[i]   = collide;
          end
          MODE_ARB:  grant_o[i] = ~rot_lose;
          MODE_PRIO: grant_o[i] = ~prio_lose;
          MODE_COMMON: begin
            grant_o[i] = data_ok;
            err_o[i]   = ~data_ok;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cw_regfile.sv
// Register array with per-port combinational reads and granted writes.
module cw_regfile #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    we_i,
  input  logic [NPORTS*AW-1:0] wr_addr_i,
  input  logic [NPORTS*DW-1:0] wr_data_i,
  input  logic [NPORTS*AW-1:0] rd_addr_i,
  output logic [NPORTS*DW-1:0] rd_data_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0][DW-1:0] mem_d;
  logic                     mem_en;

  assign mem_en = |we_i;

  always_comb begin
    mem_d = mem_q;
    for (int a = 0; a < DEPTH; a++) begin
      for (int i = NPORTS - 1; i >= 0; i--) begin
        if (we_i[i] && (wr_addr_i[i*AW +: AW] == AW'(a)))
          mem_d[a] = wr_data_i[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_rd
    assign rd_data_o[gp*DW +: DW] = mem_q[rd_addr_i[gp*AW +: AW]];
  end

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |=> $stable(mem_q));
endmodule

// File: rtl/cw_resolver.sv
module cw_resolver #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic [1:0]           mode_i,
  input  logic [NPORTS-1:0]    wr_valid_i,
  input  logic [NPORTS*AW-1:0] wr_addr_i,
  input  logic [NPORTS*DW-1:0] wr_data_i,
  input  logic [NPORTS*AW-1:0] rd_addr_i,
  output logic [NPORTS*DW-1:0] rd_data_o,
  output logic [NPORTS-1:0]    grant_o,
  output logic [NPORTS-1:0]    err_o
);
  import cw_pkg::*;

  logic [NPORTS-1:0]             req_valid;
  logic [NPORTS-1:0][NPORTS-1:0] hit;
  logic [NPORTS-1:0][NPORTS-1:0] same;
  logic [NPORTS-1:0]             grant_d, err_d;
  logic [NPORTS-1:0]             grant_q, err_q;
  logic [PW-1:0]                 ptr_q, ptr_d;
  mode_e                         mode;

  assign req_valid = wr_valid_i & {NPORTS{step_i}};
  assign mode      = mode_e'(mode_i);

  cw_match #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) match_i (
    .valid_i (req_valid),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .hit_o   (hit),
    .same_o  (same)
  );

  cw_arbiter #(.NPORTS(NPORTS)) arb_i (
    .valid_i (req_valid),
    .hit_i   (hit),
    .same_i  (same),
    .mode_i  (mode),
    .ptr_i   (ptr_q),
    .grant_o (grant_d),
    .err_o   (err_d)
  );

  cw_regfile #(.NPORTS(NPORTS), .DEPTH(DEPTH), .DW(DW)) rf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (grant_d),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // Rotating pointer for the arbitrary rule: advances once per step.
  always_comb begin
    ptr_d = ptr_q;
    if (step_i) ptr_d = (int'(ptr_q) == NPORTS - 1) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      grant_q <= '0;
      err_q   <= '0;
    end else begin
      ptr_q   <= ptr_d;
      grant_q <= grant_d;
      err_q   <= err_d;
    end
  end

  assign grant_o = grant_q;
  assign err_o   = err_q;

  // R9
  pulse_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> (grant_o == '0 && err_o == '0));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(ptr_q));

  // R4
  prio_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mode == MODE_PRIO && wr_valid_i[0]) |=> grant_o[0]);

  if (NPORTS > 1) begin : g_pair_chk
    // R8
    excl_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && mode == MODE_EXCL && wr_valid_i[0] && wr_valid_i[1] &&
       wr_addr_i[0 +: AW] == wr_addr_i[AW +: AW])
      |=> (err_o[0] && err_o[1] && !grant_o[0] && !grant_o[1]));

    // R7
    common_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && mode == MODE_COMMON && wr_valid_i[0] && wr_valid_i[1] &&
       wr_addr_i[0 +: AW] == wr_addr_i[AW +: AW] &&
       wr_data_i[0 +: DW] != wr_data_i[DW +: DW])
      |=> (err_o[0] && err_o[1] && !grant_o[0]));

    // R5
    ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (ptr_q != $past(ptr_q)));
  end
endmodule

// File: tb/cw_resolver_tb.sv
module cw_resolver_tb_top;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step;
  logic [1:0]    mode;
  logic [N-1:0]  valid;
  logic [N*AW-1:0] waddr;
  logic [N*DW-1:0] wdata;
  logic [N*AW-1:0] raddr;
  logic [N*DW-1:0] rdata;
  logic [N-1:0]  grant, err;

  int checks = 0;
  int errors = 0;
  int nsteps = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cw_resolver #(.NPORTS(N), .DEPTH(8), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step), .mode_i(mode),
    .wr_valid_i(valid), .wr_addr_i(waddr), .wr_data_i(wdata),
    .rd_addr_i(raddr), .rd_data_o(rdata), .grant_o(grant), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input int p, input int a, input logic [7:0] exp);
    raddr[p*AW +: AW] = AW'(a);
    #1;
    chk(req, 32'(rdata[p*DW +: DW]), 32'(exp));
  endtask

  // Issues one step, then checks the grant/err pulse in the following cycle.
  task automatic run_step(input string req, input logic [1:0] m, input logic [3:0] v,
                          input logic [11:0] a, input logic [31:0] d,
                          input logic [3:0] eg, input logic [3:0] ee);
    @(negedge clk);
    mode = m; valid = v; waddr = a; wdata = d; step = 1'b1;
    @(posedge clk);
    nsteps++;
    #1;
    chk({req, " grant"}, 32'(grant), 32'(eg));
    chk({req, " err"},   32'(err),   32'(ee));
    @(negedge clk);
    step = 1'b0; valid = '0;
  endtask

  function automatic logic [3:0] arb_expect(input logic [3:0] v, input int ptr);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (ptr + k) % N;
      if (v[idx]) return 4'(1 << idx);
    end
    return 4'b0;
  endfunction

  task automatic t_reset;
    for (int a = 0; a < 8; a++) rd_chk("R1 mem", 0, a, 8'h00);
    chk("R1 grant", 32'(grant), 0);
    chk("R1 err",   32'(err),   0);
  endtask

  task automatic t_distinct;
    run_step("R2", 2'd2, 4'b1111, {3'd4, 3'd3, 3'd2, 3'd1},
             {8'd44, 8'd33, 8'd22, 8'd11}, 4'b1111, 4'b0000);
    rd_chk("R2 a1", 0, 1, 8'd11);
    rd_chk("R2 a2", 1, 2, 8'd22);
    rd_chk("R2 a3", 2, 3, 8'd33);
    rd_chk("R2 a4", 3, 4, 8'd44);
  endtask

  task automatic t_read_old;
    @(negedge clk);
    mode = 2'd2; valid = 4'b0001; waddr = {3'd0, 3'd0, 3'd0, 3'd1};
    wdata = {24'h0, 8'h99}; step = 1'b1;
    rd_chk("R3 pre-step read", 2, 1, 8'd11);
    @(posedge clk);
    nsteps++;
    #1;
    chk("R3 grant", 32'(grant), 32'h1);
    rd_chk("R3 post-step read", 2, 1, 8'h99);
    @(negedge clk);
    step = 1'b0; valid = '0;
  endtask

  task automatic t_prio;
    run_step("R4", 2'd2, 4'b1110, {3'd5, 3'd5, 3'd5, 3'd0},
             {8'hA3, 8'hA2, 8'hA1, 8'h00}, 4'b0010, 4'b0000);
    rd_chk("R4 mem5", 0, 5, 8'hA1);
  endtask

  task automatic t_arb(input logic [3:0] v, input logic [7:0] base);
    logic [3:0] eg;
    int w;
    eg = arb_expect(v, nsteps % N);
    w = 0;
    for (int k = 0; k < N; k++) if (eg[k]) w = k;
    run_step("R5", 2'd1, v, {3'd6, 3'd6, 3'd6, 3'd6},
             {base + 8'd3, base + 8'd2, base + 8'd1, base}, eg, 4'b0000);
    rd_chk("R5 mem6", 0, 6, base + 8'(w));
  endtask

  task automatic t_common_eq;
    run_step("R6", 2'd3, 4'b0111, {3'd0, 3'd7, 3'd0, 3'd7},
             {8'h00, 8'h55, 8'h10, 8'h55}, 4'b0111, 4'b0000);
    rd_chk("R6 mem7", 0, 7, 8'h55);
    rd_chk("R6 mem0", 1, 0, 8'h10);
  endtask

  task automatic t_common_ne;
    run_step("R7", 2'd3, 4'b1011, {3'd7, 3'd0, 3'd2, 3'd7},
             {8'h22, 8'h00, 8'h77, 8'h11}, 4'b0010, 4'b1001);
    rd_chk("R7 mem7 kept", 0, 7, 8'h55);
    rd_chk("R7 mem2 other", 1, 2, 8'h77);
  endtask

  task automatic t_excl;
    run_step("R8", 2'd0, 4'b0111, {3'd0, 3'd3, 3'd3, 3'd4},
             {8'h00, 8'h02, 8'h01, 8'h4C}, 4'b0001, 4'b0110);
    rd_chk("R8 mem3 kept", 0, 3, 8'd33);
    rd_chk("R8 mem4", 1, 4, 8'h4C);
  endtask

  task automatic t_idle;
    @(posedge clk); #1;
    chk("R9 grant pulse ends", 32'(grant), 0);
    chk("R9 err pulse ends",   32'(err),   0);
    @(negedge clk);
    mode = 2'd3; valid = 4'b1111; waddr = '0; wdata = 32'hFFFF_FFFF; step = 1'b0;
    @(posedge clk); #1;
    chk("R10 no grant w/o step", 32'(grant), 0);
    @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    valid = '0;
    rd_chk("R10 mem0 untouched", 0, 0, 8'h10);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; mode = '0; valid = '0;
    waddr = '0; wdata = '0; raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_distinct();
    t_read_old();
    t_prio();
    t_arb(4'b1111, 8'h60);
    t_arb(4'b1111, 8'h70);
    t_arb(4'b0011, 8'h80);
    t_arb(4'b0110, 8'h90);
    t_common_eq();
    t_common_ne();
    t_excl();
    t_idle();
    t_arb(4'b1111, 8'hB0);
    t_arb(4'b1001, 8'hC0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule